// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path. At each instruction boundary the core raises a step strobe and presents what is pending: a synchronous exception with its event code, and an interrupt request from the interrupt controller with a vector and a priority level. The block makes one decision for that boundary. It can ignore the events, take an exception, take an interrupt, or escalate to a reset request.

When an event is taken, the block runs the entry sequence in one clock. It saves the status word, the return PC and the stack pointer (R15). It builds the handler's status word and selects the handler address from the event type. It latches the event code into the exception or interrupt event register. It also pulses strobes that tell the core to clear its sleep and delay-slot flags.

The `entry_o` pulse also tells the core to drop any load-lock reservation.

Top module: `evt_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending at the same step, the exception is taken. `expevt_o` takes the exception code and `intevt_o` keeps its previous value.
- R2: When status bit 28 (block) is set and an exception with a code other than 0x1E0 is pending, `reset_req_o` pulses for one cycle. No entry happens, and the saved and event registers keep their values.
- R3: An exception with code 0x1E0 is entered normally even when status bit 28 is set.
- R4: While status bit 28 is set, an interrupt is ignored unless `sleep_i` is high. Every taken event pulses `sleep_clr_o` if `sleep_i` was high at the step.
- R5: An interrupt is accepted only when its 4-bit level is strictly greater than the mask held in status bits 7:4.
- R6: On entry, `ssr_o` gets `sr_i`, `spc_o` gets `pc_i` and `sgr_o` gets `r15_i`. `sr_o` is `sr_i` with bit 28 (block), bit 30 (privileged) and bit 29 (register bank) set.
- R7: If `dslot_i` is high at a taken event, `spc_o` is `pc_i` minus 2 and `dslot_clr_o` pulses.
- R8: Exception codes 0x000, 0x020 and 0x140 do three things: clear status bit 15 (FPU disable), set bits 7:4 to 0xF, and branch to 0xA0000000.
- R9: Exception codes 0x040 and 0x060 branch to `vbr_i` + 0x400.
- R10: Exception code 0x160 adds 2 to the saved PC. Code 0x160 and every code not named in R8 or R9 branch to `vbr_i` + 0x100. Every taken exception writes its code to `expevt_o`.
- R11: An accepted interrupt writes its vector to `intevt_o` and branches to `vbr_i` + 0x600.
- R12: An interrupt is never taken while `dslot_i` is high. An exception at the same step is still taken.
- R13: All results appear on the clock edge that samples `step_i`. `entry_o` lasts exactly one cycle. Without `step_i` nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction boundary strobe |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_code_i | input | 12 | Exception event code |
| irq_req_i | input | 1 | Interrupt request |
| irq_vec_i | input | 12 | Interrupt vector code |
| irq_lvl_i | input | 4 | Interrupt priority level |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | PC of the interrupted instruction |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector base |
| sleep_i | input | 1 | Core is sleeping |
| dslot_i | input | 1 | Boundary is inside a delay slot |
| entry_o | output | 1 | One-cycle handler entry pulse |
| reset_req_o | output | 1 | One-cycle reset request |
| sleep_clr_o | output | 1 | Clear sleep flag strobe |
| dslot_clr_o | output | 1 | Clear delay-slot flag strobe |
| new_pc_o | output | 32 | Handler address |
| sr_o | output | 32 | Handler status word |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Exception event register |
| intevt_o | output | 12 | Interrupt event register |

## Verification
The hardest cases to reach are the ones where several qualifiers meet in one step. One is a blocked core that is asleep when an interrupt arrives. Another is a trap instruction inside a delay slot, where the rewind and the trap adjustment cancel out. A third is an exception and an interrupt that arrive together while the delay-slot flag is set. The stimulus drives each combination directly on the status word, sleep and delay-slot inputs for a single step. Before each case, an earlier scenario loads a known value into the event registers. That makes it visible when a register was left untouched.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 12;
  localparam int LVL_W  = 4;

  // status word fields decoded by the core
  localparam int SR_BLK  = 28;
  localparam int SR_BANK = 29;
  localparam int SR_PRIV = 30;
  localparam int SR_FPD  = 15;
  localparam int SR_MSK_LO = 4;

  localparam logic [CODE_W-1:0] C_PWR_RST  = 12'h000;
  localparam logic [CODE_W-1:0] C_MAN_RST  = 12'h020;
  localparam logic [CODE_W-1:0] C_MULTI    = 12'h140;
  localparam logic [CODE_W-1:0] C_MISS_RD  = 12'h040;
  localparam logic [CODE_W-1:0] C_MISS_WR  = 12'h060;
  localparam logic [CODE_W-1:0] C_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] C_BLK_OK   = 12'h1E0;

  localparam logic [XLEN-1:0] RST_VEC    = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFS_GEN    = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_MISS   = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0600;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int LW = LVL_W
) (
  input  logic          step_i,
  input  logic          exc_valid_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic          irq_req_i,
  input  logic [LW-1:0] irq_lvl_i,
  input  logic [LW-1:0] imask_i,
  input  logic          blk_i,
  input  logic          sleep_i,
  input  logic          dslot_i,
  output ev_kind_e      kind_o,
  output logic          esc_o
);
  logic exc_p, irq_p, irq_ok, exc_blocked;

  always_comb begin
    exc_p       = step_i && exc_valid_i;
    irq_p       = step_i && irq_req_i && !exc_valid_i && !dslot_i;
    exc_blocked = exc_p && blk_i && (exc_code_i != C_BLK_OK);
    irq_ok      = irq_p && (irq_lvl_i > imask_i) && (!blk_i || sleep_i);
    esc_o       = exc_blocked;
    if (exc_p && !exc_blocked) kind_o = EV_EXC;
    else if (irq_ok)           kind_o = EV_IRQ;
    else                       kind_o = EV_NONE;
  end
endmodule

// File: rtl/evt_target.sv
module evt_target
  import evt_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int CW = CODE_W
) (
  input  ev_kind_e      kind_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic [XW-1:0] sr_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] vbr_i,
  input  logic          dslot_i,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] sr_o,
  output logic [XW-1:0] spc_o
);
  localparam logic [XW-1:0] TWO = XW'(2);

  always_comb begin
    sr_o = sr_i;
    sr_o[SR_BLK]  = 1'b1;
    sr_o[SR_PRIV] = 1'b1;
    sr_o[SR_BANK] = 1'b1;
    spc_o = dslot_i ? (pc_i - TWO) : pc_i;
    pc_o  = vbr_i + OFS_GEN;
    if (kind_i == EV_IRQ) begin
      pc_o = vbr_i + OFS_IRQ;
    end else begin
      unique case (exc_code_i)
        C_PWR_RST, C_MAN_RST, C_MULTI: begin
          sr_o[SR_FPD] = 1'b0;
          sr_o[SR_MSK_LO+3:SR_MSK_LO] = 4'hF;
          pc_o = RST_VEC;
        end
        C_MISS_RD, C_MISS_WR: pc_o = vbr_i + OFS_MISS;
        C_TRAP: spc_o = spc_o + TWO;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_entry_seq.sv
module evt_entry_seq
  import evt_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int CW = CODE_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          exc_valid_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic          irq_req_i,
  input  logic [CW-1:0] irq_vec_i,
  input  logic [LW-1:0] irq_lvl_i,
  input  logic [XW-1:0] sr_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] r15_i,
  input  logic [XW-1:0] vbr_i,
  input  logic          sleep_i,
  input  logic          dslot_i,
  output logic          entry_o,
  output logic          reset_req_o,
  output logic          sleep_clr_o,
  output logic          dslot_clr_o,
  output logic [XW-1:0] new_pc_o,
  output logic [XW-1:0] sr_o,
  output logic [XW-1:0] ssr_o,
  output logic [XW-1:0] spc_o,
  output logic [XW-1:0] sgr_o,
  output logic [CW-1:0] expevt_o,
  output logic [CW-1:0] intevt_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  ev_kind_e      kind;
  logic          esc;
  logic          take;
  logic [XW-1:0] nx_pc, nx_sr, nx_spc;
  logic          irq_kind_q;

  evt_arbiter #(.CW(CW), .LW(LW)) u_arb (
    .step_i      (step_i),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_req_i   (irq_req_i),
    .irq_lvl_i   (irq_lvl_i),
    .imask_i     (sr_i[SR_MSK_LO+LW-1:SR_MSK_LO]),
    .blk_i       (sr_i[SR_BLK]),
    .sleep_i     (sleep_i),
    .dslot_i     (dslot_i),
    .kind_o      (kind),
    .esc_o       (esc)
  );

  evt_target #(.XW(XW), .CW(CW)) u_tgt (
    .kind_i     (kind),
    .exc_code_i (exc_code_i),
    .sr_i       (sr_i),
    .pc_i       (pc_i),
    .vbr_i      (vbr_i),
    .dslot_i    (dslot_i),
    .pc_o       (nx_pc),
    .sr_o       (nx_sr),
    .spc_o      (nx_spc)
  );

  assign take = (kind != EV_NONE);

  // pulse strobes
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      entry_o     <= 1'b0;
      reset_req_o <= 1'b0;
      sleep_clr_o <= 1'b0;
      dslot_clr_o <= 1'b0;
    end else begin
      entry_o     <= take;
      reset_req_o <= esc;
      sleep_clr_o <= take && sleep_i;
      dslot_clr_o <= take && dslot_i;
    end
  end

  // context registers, loaded only on entry
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      new_pc_o   <= '0;
      sr_o       <= '0;
      ssr_o      <= '0;
      spc_o      <= '0;
      sgr_o      <= '0;
      irq_kind_q <= 1'b0;
    end else if (take) begin
      new_pc_o   <= nx_pc;
      sr_o       <= nx_sr;
      ssr_o      <= sr_i;
      spc_o      <= nx_spc;
      sgr_o      <= r15_i;
      irq_kind_q <= (kind == EV_IRQ);
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)            expevt_o <= '0;
    else if (kind == EV_EXC)  expevt_o <= exc_code_i;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)            intevt_o <= '0;
    else if (kind == EV_IRQ)  intevt_o <= irq_vec_i;
  end

  // R1: exception wins over a simultaneous interrupt
  assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_in_n)
    (step_i && exc_valid_i && irq_req_i && !sr_i[SR_BLK]) |=> (entry_o && !irq_kind_q));

  // R2: blocked exception escalates to reset instead of entering
  assert_blk_escalate_R2: assert property (@(posedge clk) disable iff (!rst_in_n)
    (step_i && exc_valid_i && sr_i[SR_BLK] && exc_code_i != C_BLK_OK)
      |=> (reset_req_o && !entry_o && $stable(expevt_o) && $stable(spc_o)));

  // R6: handler status always has block, privilege and bank set
  assert_entry_sr_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
    entry_o |-> (sr_o[SR_BLK] && sr_o[SR_PRIV] && sr_o[SR_BANK]));

  // R12: no interrupt taken inside a delay slot
  assert_dslot_irq_R12: assert property (@(posedge clk) disable iff (!rst_in_n)
    (step_i && dslot_i && !exc_valid_i) |=> (!entry_o && $stable(intevt_o)));

  // R13: nothing changes without a step
  assert_no_step_R13: assert property (@(posedge clk) disable iff (!rst_in_n)
    !step_i |=> (!entry_o && !reset_req_o && $stable(spc_o) && $stable(expevt_o)));

  // R13: entry and reset request never coincide
  assert_excl_R13: assert property (@(posedge clk) disable iff (!rst_in_n)
    !(entry_o && reset_req_o));
endmodule

// File: tb/evt_entry_seq_bench.sv
module evt_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, exc_valid_i, irq_req_i, sleep_i, dslot_i;
  logic [11:0] exc_code_i, irq_vec_i;
  logic [3:0]  irq_lvl_i;
  logic [31:0] sr_i, pc_i, r15_i, vbr_i;
  logic        entry_o, reset_req_o, sleep_clr_o, dslot_clr_o;
  logic [31:0] new_pc_o, sr_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] PC  = 32'h0C00_1000;
  localparam logic [31:0] R15 = 32'h0CFF_0000;
  localparam logic [31:0] ENTRY_BITS = 32'h7000_0000;

  always #4 clk = ~clk;

  evt_entry_seq u_evt_entry_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_vec_i(irq_vec_i),
    .irq_lvl_i(irq_lvl_i), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i),
    .vbr_i(vbr_i), .sleep_i(sleep_i), .dslot_i(dslot_i),
    .entry_o(entry_o), .reset_req_o(reset_req_o), .sleep_clr_o(sleep_clr_o),
    .dslot_clr_o(dslot_clr_o), .new_pc_o(new_pc_o), .sr_o(sr_o),
    .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o),
    .intevt_o(intevt_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    step_i = 0; exc_valid_i = 0; irq_req_i = 0; sleep_i = 0; dslot_i = 0;
    exc_code_i = 0; irq_vec_i = 0; irq_lvl_i = 0;
  endtask

  // drive one boundary; return with outputs registered, sampled at negedge
  task automatic step(bit ev, logic [11:0] code, bit iq, logic [11:0] vec,
                      logic [3:0] lvl, logic [31:0] sr, bit slp, bit ds);
    @(negedge clk);
    step_i = 1; exc_valid_i = ev; exc_code_i = code; irq_req_i = iq;
    irq_vec_i = vec; irq_lvl_i = lvl; sr_i = sr; sleep_i = slp; dslot_i = ds;
    pc_i = PC; r15_i = R15; vbr_i = VBR;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_gone(string req);
    @(negedge clk);
    chk(req, "entry pulse width", {31'd0, entry_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R13", "entry after reset", {31'd0, entry_o}, 0);
    chk("R13", "expevt after reset", {20'd0, expevt_o}, 0);
    chk("R13", "spc after reset", spc_o, 0);
  endtask

  task automatic t_general();
    logic [31:0] sr = 32'h0000_80F0;
    step(1, 12'h0E0, 0, 0, 0, sr, 0, 0);
    chk("R6", "entry", {31'd0, entry_o}, 1);
    chk("R6", "ssr", ssr_o, sr);
    chk("R6", "spc", spc_o, PC);
    chk("R6", "sgr", sgr_o, R15);
    chk("R6", "sr", sr_o, sr | ENTRY_BITS);
    chk("R10", "pc", new_pc_o, VBR + 32'h100);
    chk("R10", "expevt", {20'd0, expevt_o}, 32'h0E0);
    pulse_gone("R13");
  endtask

  task automatic t_reset_class();
    logic [31:0] sr = 32'h0000_8030;
    step(1, 12'h140, 0, 0, 0, sr, 0, 0);
    chk("R8", "pc", new_pc_o, 32'hA000_0000);
    chk("R8", "sr", sr_o, ((sr | ENTRY_BITS) & ~32'h8000) | 32'hF0);
    step(1, 12'h020, 0, 0, 0, sr, 0, 0);
    chk("R8", "pc 0x020", new_pc_o, 32'hA000_0000);
    chk("R10", "expevt 0x020", {20'd0, expevt_o}, 32'h020);
  endtask

  task automatic t_miss();
    step(1, 12'h040, 0, 0, 0, 32'h0, 0, 0);
    chk("R9", "pc 0x040", new_pc_o, VBR + 32'h400);
    step(1, 12'h060, 0, 0, 0, 32'h0, 0, 0);
    chk("R9", "pc 0x060", new_pc_o, VBR + 32'h400);
  endtask

  task automatic t_trap();
    step(1, 12'h160, 0, 0, 0, 32'h0, 0, 0);
    chk("R10", "trap spc", spc_o, PC + 2);
    chk("R10", "trap pc", new_pc_o, VBR + 32'h100);
    step(1, 12'h160, 0, 0, 0, 32'h0, 0, 1);
    chk("R7", "trap in slot spc", spc_o, PC);
  endtask

  task automatic t_dslot_exc();
    step(1, 12'h0E0, 0, 0, 0, 32'h0, 0, 1);
    chk("R7", "slot spc", spc_o, PC - 2);
    chk("R7", "slot clear", {31'd0, dslot_clr_o}, 1);
  endtask

  task automatic t_irq();
    logic [11:0] prev;
    step(0, 0, 1, 12'h3C0, 4'd5, 32'h0000_0030, 0, 0);
    chk("R11", "irq entry", {31'd0, entry_o}, 1);
    chk("R11", "intevt", {20'd0, intevt_o}, 32'h3C0);
    chk("R11", "irq pc", new_pc_o, VBR + 32'h600);
    prev = intevt_o;
    step(0, 0, 1, 12'h500, 4'd3, 32'h0000_0030, 0, 0);
    chk("R5", "equal level entry", {31'd0, entry_o}, 0);
    chk("R5", "equal level intevt", {20'd0, intevt_o}, {20'd0, prev});
    step(0, 0, 1, 12'h520, 4'd4, 32'h0000_0030, 0, 0);
    chk("R5", "higher level intevt", {20'd0, intevt_o}, 32'h520);
  endtask

  task automatic t_priority();
    logic [11:0] prev = intevt_o;
    step(1, 12'h180, 1, 12'h600, 4'd15, 32'h0, 0, 0);
    chk("R1", "expevt", {20'd0, expevt_o}, 32'h180);
    chk("R1", "intevt kept", {20'd0, intevt_o}, {20'd0, prev});
    chk("R1", "pc", new_pc_o, VBR + 32'h100);
  endtask

  task automatic t_blocked();
    logic [31:0] blk = 32'h1000_0000;
    logic [11:0] pe = expevt_o;
    logic [31:0] ps = spc_o;
    logic [11:0] pi;
    step(1, 12'h0E0, 0, 0, 0, blk, 0, 0);
    chk("R2", "reset req", {31'd0, reset_req_o}, 1);
    chk("R2", "no entry", {31'd0, entry_o}, 0);
    chk("R2", "expevt kept", {20'd0, expevt_o}, {20'd0, pe});
    chk("R2", "spc kept", spc_o, ps);
    @(negedge clk);
    chk("R2", "reset pulse width", {31'd0, reset_req_o}, 0);
    step(1, 12'h1E0, 0, 0, 0, blk, 0, 0);
    chk("R3", "1E0 entry", {31'd0, entry_o}, 1);
    chk("R3", "1E0 expevt", {20'd0, expevt_o}, 32'h1E0);
    chk("R3", "1E0 reset req", {31'd0, reset_req_o}, 0);
    pi = intevt_o;
    step(0, 0, 1, 12'h240, 4'd9, blk, 0, 0);
    chk("R4", "blocked irq entry", {31'd0, entry_o}, 0);
    chk("R4", "blocked irq intevt", {20'd0, intevt_o}, {20'd0, pi});
    step(0, 0, 1, 12'h240, 4'd9, blk, 1, 0);
    chk("R4", "sleep irq entry", {31'd0, entry_o}, 1);
    chk("R4", "sleep clear", {31'd0, sleep_clr_o}, 1);
    chk("R4", "sleep irq intevt", {20'd0, intevt_o}, 32'h240);
  endtask

  task automatic t_dslot_irq();
    logic [11:0] pi = intevt_o;
    step(0, 0, 1, 12'h7A0, 4'd15, 32'h0, 0, 1);
    chk("R12", "slot irq entry", {31'd0, entry_o}, 0);
    chk("R12", "slot irq intevt", {20'd0, intevt_o}, {20'd0, pi});
    step(1, 12'h0A0, 1, 12'h7A0, 4'd15, 32'h0, 0, 1);
    chk("R12", "slot exc entry", {31'd0, entry_o}, 1);
    chk("R12", "slot exc expevt", {20'd0, expevt_o}, 32'h0A0);
  endtask

  task automatic t_no_step();
    logic [11:0] pe = expevt_o;
    @(negedge clk);
    exc_valid_i = 1; exc_code_i = 12'h0C0; irq_req_i = 1; irq_lvl_i = 4'd15;
    sr_i = 32'h0;
    @(negedge clk);
    chk("R13", "no step entry", {31'd0, entry_o}, 0);
    chk("R13", "no step expevt", {20'd0, expevt_o}, {20'd0, pe});
    idle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    idle();
    sr_i = 0; pc_i = 0; r15_i = 0; vbr_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_general();
    t_reset_class();
    t_miss();
    t_trap();
    t_dslot_exc();
    t_irq();
    t_priority();
    t_blocked();
    t_dslot_irq();
    t_no_step();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule